// File: doc/BRIEF.md
# Cache Event Counter Bank

This block is a bank of event counters plus one free-running cycle counter, all reached through a single indexed register port. Each event counter watches one of a set of event-strobe inputs, chosen by its type register, and adds one on every clock in which that strobe is high and counting is allowed. The cycle counter adds one on every clock while it is allowed to run. Software preloads counter values, starts and stops counting with a global enable, and turns individual counters and their interrupts on and off through paired write-one-to-set and write-one-to-clear addresses.

When a counter passes its all-ones value it wraps to zero and raises a sticky overflow bit. The interrupt output is a level: it is high while any overflow bit is set whose interrupt enable is also set, and it falls only when software clears those overflow bits. The per-counter control and filter registers are plain storage for software. They do not affect counting.

Top module: `pmc_bank`

## Requirements
- R1: After reset every counter value, the enable mask, the interrupt-enable mask and the overflow mask are zero, and `irq` is low.
- R2: The global control register sits at index 0x400. A read returns the number of event counters in bits 15:11 and the global enable in bit 0. Writing bit 0 sets the enable, and while it is 0 no counter changes except by a register write.
- R3: The enable mask is written at 0x404 (ones set bits) and 0x403 (ones clear bits). The interrupt-enable mask uses 0x406 and 0x405, and the overflow mask uses 0x408 and 0x407, in the same way. A read of either address of a pair returns that mask. Event counter i owns bit i and the cycle counter owns bit 31. All other bits always read zero.
- R4: Event counter i (value at 0x421 + 16*i, type at 0x424 + 16*i) adds one on each clock where the global enable, enable bit i and strobe input number `type` are all high. A type value at or above the strobe count selects no input.
- R5: Event counters are 32 bits wide. An increment from 0xFFFFFFFF gives zero and sets overflow bit i.
- R6: The cycle counter (value at 0x40A) is 64 bits wide. It adds one on every clock while the global enable and enable bit 31 are high, and its wrap sets overflow bit 31.
- R7: A write to 0x400 with bit 1 set zeroes all event counter values, and bit 2 zeroes the cycle counter, so 0x6 zeroes all of them. The enable masks are unchanged.
- R8: Counter values are writable. A value write in the same cycle as an increment stores the written value.
- R9: `irq` is high exactly while some overflow bit and its interrupt-enable bit are both set. It stays high until that overflow bit is cleared through 0x407.
- R10: Read data appears on `reg_rdata` one clock after the read request. Reads of unmapped indices or of counters beyond the implemented count return zero, and writes to them change nothing.
- R11: The per-counter control (0x420 + 16*i), filter (0x423 + 16*i) and cycle control (0x409) registers store the low 32 bits written and read them back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_strobe | input | NUM_STROBE | One-cycle event pulses from the cache |
| reg_valid | input | 1 | Register access request |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_index | input | ADDR_W | Register index |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, valid one clock after a read |
| irq | output | 1 | Level overflow interrupt |

## Verification
A register write lands at the clock edge that samples the request, so a value written there can be read by the very next request. Read data is registered, so the bench samples `reg_rdata` at the falling edge after the capturing rising edge. Strobe pulses are driven between falling edges, so each pulse covers exactly one rising edge. Event counts are therefore exact, and they are checked only after the global enable has been written back to zero. The cycle counter runs every clock and a count depends on task overhead, so its check bounds the value after a known wrap instead of matching it exactly.

// File: rtl/pmc_pkg.sv
`timescale 1ns/1ps
package pmc_pkg;

   // Fixed register indices; software depends on these positions.
   localparam int A_GCTRL    = 'h400;
   localparam int A_EN_CLR   = 'h403;
   localparam int A_EN_SET   = 'h404;
   localparam int A_IE_CLR   = 'h405;
   localparam int A_IE_SET   = 'h406;
   localparam int A_OV_CLR   = 'h407;
   localparam int A_OV_SET   = 'h408;
   localparam int A_CYC_CTRL = 'h409;
   localparam int A_CYC_VAL  = 'h40A;

   // Event counter window: base plus fixed stride per counter.
   localparam int EV_BASE    = 'h420;
   localparam int EV_STRIDE  = 16;
   localparam int SUB_CTRL   = 0;
   localparam int SUB_VAL    = 1;
   localparam int SUB_FILT   = 3;
   localparam int SUB_TYPE   = 4;

   // Mask geometry.
   localparam int MASK_W     = 32;
   localparam int CYC_BIT    = 31;

   // Global control fields.
   localparam int G_EN_BIT   = 0;
   localparam int G_RST_EVT  = 1;
   localparam int G_RST_CYC  = 2;
   localparam int CNT_LSB    = 11;
   localparam int CNT_W      = 5;

   typedef enum logic [3:0] {
      RK_NONE,
      RK_GCTRL,
      RK_EN_CLR,
      RK_EN_SET,
      RK_IE_CLR,
      RK_IE_SET,
      RK_OV_CLR,
      RK_OV_SET,
      RK_CYC_CTRL,
      RK_CYC_VAL,
      RK_EV_CTRL,
      RK_EV_VAL,
      RK_EV_FILT,
      RK_EV_TYPE
   } reg_kind_e;

   typedef struct packed {
      reg_kind_e   kind;
      logic [7:0]  ctr;
   } decode_t;

endpackage

// File: rtl/pmc_addr_decode.sv
`timescale 1ns/1ps
module pmc_addr_decode
   import pmc_pkg::*;
#(
   parameter int ADDR_W  = 12,
   parameter int NUM_EVT = 8
) (
   input  logic [ADDR_W-1:0] index,
   output decode_t           dec
);

   localparam int SUB_W = $clog2(EV_STRIDE);
   localparam logic [ADDR_W-1:0] EV_LO   = ADDR_W'(EV_BASE);
   localparam logic [ADDR_W-1:0] EV_SPAN = ADDR_W'(NUM_EVT * EV_STRIDE);

   if (EV_BASE + NUM_EVT * EV_STRIDE > (1 << ADDR_W)) begin : g_bad_addr_w
      $error("pmc_addr_decode: ADDR_W too small for counter window");
   end

   logic [ADDR_W-1:0] off;
   assign off = index - EV_LO;

   always_comb begin
      dec.kind = RK_NONE;
      dec.ctr  = '0;
      if (index >= EV_LO && off < EV_SPAN) begin
         dec.ctr = 8'(off >> SUB_W);
         case (off[SUB_W-1:0])
            SUB_W'(SUB_CTRL): dec.kind = RK_EV_CTRL;
            SUB_W'(SUB_VAL):  dec.kind = RK_EV_VAL;
            SUB_W'(SUB_FILT): dec.kind = RK_EV_FILT;
            SUB_W'(SUB_TYPE): dec.kind = RK_EV_TYPE;
            default:          dec.kind = RK_NONE;
         endcase
      end else begin
         case (index)
            ADDR_W'(A_GCTRL):    dec.kind = RK_GCTRL;
            ADDR_W'(A_EN_CLR):   dec.kind = RK_EN_CLR;
            ADDR_W'(A_EN_SET):   dec.kind = RK_EN_SET;
            ADDR_W'(A_IE_CLR):   dec.kind = RK_IE_CLR;
            ADDR_W'(A_IE_SET):   dec.kind = RK_IE_SET;
            ADDR_W'(A_OV_CLR):   dec.kind = RK_OV_CLR;
            ADDR_W'(A_OV_SET):   dec.kind = RK_OV_SET;
            ADDR_W'(A_CYC_CTRL): dec.kind = RK_CYC_CTRL;
            ADDR_W'(A_CYC_VAL):  dec.kind = RK_CYC_VAL;
            default:             dec.kind = RK_NONE;
         endcase
      end
   end

endmodule

// File: rtl/pmc_mask_reg.sv
`timescale 1ns/1ps
module pmc_mask_reg #(
   parameter int          W    = 32,
   parameter logic [W-1:0] IMPL = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         set_we,
   input  logic         clr_we,
   input  logic [W-1:0] wd,
   input  logic [W-1:0] hw_set,
   output logic [W-1:0] q
);

   logic [W-1:0] set_bits;
   logic [W-1:0] clr_bits;

   assign set_bits = set_we ? wd : '0;
   assign clr_bits = clr_we ? wd : '0;

   // Hardware and software set both dominate a same-cycle clear.
   always_ff @(posedge clk) begin
      if (!rst_n) q <= '0;
      else        q <= ((q & ~clr_bits) | set_bits | hw_set) & IMPL;
   end

   // R3
   mask_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_we && !set_we) |=> ((q & $past(wd) & ~$past(hw_set)) == '0));

   // R3
   mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_we |=> ((q & $past(wd) & IMPL) == ($past(wd) & IMPL)));

endmodule

// File: rtl/pmc_counter.sv
`timescale 1ns/1ps
module pmc_counter #(
   parameter int CW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          hit,
   input  logic          clr,
   input  logic          wr,
   input  logic [CW-1:0] wd,
   output logic [CW-1:0] q,
   output logic          wrap
);

   if (CW < 2) begin : g_bad_cw
      $error("pmc_counter: CW must be at least 2");
   end

   // Priority: bulk clear, then software write, then increment.
   always_ff @(posedge clk) begin
      if (!rst_n)   q <= '0;
      else if (clr) q <= '0;
      else if (wr)  q <= wd;
      else if (hit) q <= q + 1'b1;
   end

   assign wrap = hit & ~clr & ~wr & (&q);

   // R8
   wr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && !clr) |=> (q == $past(wd)));

   // R2
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!hit && !wr && !clr) |=> $stable(q));

   // R5
   wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> (q == '0));

endmodule

// File: rtl/pmc_bank.sv
`timescale 1ns/1ps
module pmc_bank
   import pmc_pkg::*;
#(
   parameter int NUM_EVT    = 8,
   parameter int NUM_STROBE = 16,
   parameter int EVT_W      = 32,
   parameter int CYC_W      = 64,
   parameter int ADDR_W     = 12,
   parameter int DATA_W     = 64,
   parameter int REG_W      = 32
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_STROBE-1:0] evt_strobe,
   input  logic                  reg_valid,
   input  logic                  reg_write,
   input  logic [ADDR_W-1:0]     reg_index,
   input  logic [DATA_W-1:0]     reg_wdata,
   output logic [DATA_W-1:0]     reg_rdata,
   output logic                  irq
);

   localparam int SEL_W = (NUM_STROBE > 1) ? $clog2(NUM_STROBE) : 1;
   localparam int IDX_W = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1;
   localparam logic [MASK_W-1:0] EVT_BITS = (MASK_W'(1) << NUM_EVT) - MASK_W'(1);
   localparam logic [MASK_W-1:0] IMPL     = EVT_BITS | (MASK_W'(1) << CYC_BIT);
   localparam logic [REG_W-1:0]  NSTR     = REG_W'(NUM_STROBE);

   // Elaboration-time parameter checks
   if (NUM_EVT < 1 || NUM_EVT >= CYC_BIT) begin : g_bad_num_evt
      $error("pmc_bank: NUM_EVT must be 1..30");
   end
   if (NUM_STROBE < 2) begin : g_bad_strobe
      $error("pmc_bank: NUM_STROBE must be at least 2");
   end
   if (DATA_W < CYC_W || CYC_W < EVT_W || REG_W < SEL_W + 1 || REG_W < MASK_W) begin : g_bad_width
      $error("pmc_bank: inconsistent data widths");
   end
   if (DATA_W < CNT_LSB + CNT_W) begin : g_bad_data_w
      $error("pmc_bank: DATA_W too narrow for control register");
   end

   // ---------------- decode ----------------
   decode_t dec;
   pmc_addr_decode #(.ADDR_W(ADDR_W), .NUM_EVT(NUM_EVT)) u_dec (
      .index (reg_index),
      .dec   (dec)
   );

   logic wr_hit, rd_hit;
   assign wr_hit = reg_valid &  reg_write;
   assign rd_hit = reg_valid & ~reg_write;

   function automatic logic wr_to(input reg_kind_e k, input reg_kind_e d, input logic w);
      return w && (d == k);
   endfunction

   // ---------------- global control ----------------
   logic en_q, gctrl_we, rst_evt, rst_cyc;
   assign gctrl_we = wr_to(RK_GCTRL, dec.kind, wr_hit);
   assign rst_evt  = gctrl_we & reg_wdata[G_RST_EVT];
   assign rst_cyc  = gctrl_we & reg_wdata[G_RST_CYC];

   always_ff @(posedge clk) begin
      if (!rst_n)        en_q <= 1'b0;
      else if (gctrl_we) en_q <= reg_wdata[G_EN_BIT];
   end

   // ---------------- masks ----------------
   logic [MASK_W-1:0] cnt_en, int_en, ovf, ovf_hw;
   logic [NUM_EVT-1:0] ev_wrap;
   logic cyc_wrap;
   logic ie_clr_we, ov_clr_we;
   assign ie_clr_we = wr_to(RK_IE_CLR, dec.kind, wr_hit);
   assign ov_clr_we = wr_to(RK_OV_CLR, dec.kind, wr_hit);

   always_comb begin
      ovf_hw = '0;
      ovf_hw[NUM_EVT-1:0] = ev_wrap;
      ovf_hw[CYC_BIT] = cyc_wrap;
   end

   pmc_mask_reg #(.W(MASK_W), .IMPL(IMPL)) u_en (
      .clk(clk), .rst_n(rst_n),
      .set_we(wr_to(RK_EN_SET, dec.kind, wr_hit)),
      .clr_we(wr_to(RK_EN_CLR, dec.kind, wr_hit)),
      .wd(reg_wdata[MASK_W-1:0]), .hw_set('0), .q(cnt_en)
   );

   pmc_mask_reg #(.W(MASK_W), .IMPL(IMPL)) u_ie (
      .clk(clk), .rst_n(rst_n),
      .set_we(wr_to(RK_IE_SET, dec.kind, wr_hit)),
      .clr_we(ie_clr_we),
      .wd(reg_wdata[MASK_W-1:0]), .hw_set('0), .q(int_en)
   );

   pmc_mask_reg #(.W(MASK_W), .IMPL(IMPL)) u_ov (
      .clk(clk), .rst_n(rst_n),
      .set_we(wr_to(RK_OV_SET, dec.kind, wr_hit)),
      .clr_we(ov_clr_we),
      .wd(reg_wdata[MASK_W-1:0]), .hw_set(ovf_hw), .q(ovf)
   );

   assign irq = |(ovf & int_en);

   // ---------------- event counters ----------------
   logic [EVT_W-1:0] ev_cnt  [NUM_EVT];
   logic [REG_W-1:0] ev_ctrl [NUM_EVT];
   logic [REG_W-1:0] ev_filt [NUM_EVT];
   logic [REG_W-1:0] ev_type [NUM_EVT];

   for (genvar i = 0; i < NUM_EVT; i++) begin : g_ev
      logic sel_me, val_we, hit;
      logic [REG_W-1:0] ctrl_q, filt_q, type_q;

      assign sel_me = (dec.ctr == 8'(i));
      assign val_we = sel_me & wr_to(RK_EV_VAL, dec.kind, wr_hit);

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            ctrl_q <= '0;
            filt_q <= '0;
            type_q <= '0;
         end else if (sel_me && wr_hit) begin
            if (dec.kind == RK_EV_CTRL) ctrl_q <= reg_wdata[REG_W-1:0];
            if (dec.kind == RK_EV_FILT) filt_q <= reg_wdata[REG_W-1:0];
            if (dec.kind == RK_EV_TYPE) type_q <= reg_wdata[REG_W-1:0];
         end
      end

      assign hit = en_q & cnt_en[i] & (type_q < NSTR) & evt_strobe[type_q[SEL_W-1:0]];

      pmc_counter #(.CW(EVT_W)) u_ctr (
         .clk(clk), .rst_n(rst_n),
         .hit(hit), .clr(rst_evt), .wr(val_we),
         .wd(reg_wdata[EVT_W-1:0]),
         .q(ev_cnt[i]), .wrap(ev_wrap[i])
      );

      assign ev_ctrl[i] = ctrl_q;
      assign ev_filt[i] = filt_q;
      assign ev_type[i] = type_q;

      // R9
      ev_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (ev_wrap[i] && int_en[i] && !ie_clr_we) |=> irq);

      // R5
      ev_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (ev_wrap[i] && !ov_clr_we) |=> ovf[i]);
   end

   // ---------------- cycle counter ----------------
   logic [CYC_W-1:0] cyc_cnt;
   logic [REG_W-1:0] cyc_ctrl;
   logic cyc_val_we, cyc_hit;

   assign cyc_val_we = wr_to(RK_CYC_VAL, dec.kind, wr_hit);
   assign cyc_hit    = en_q & cnt_en[CYC_BIT];

   always_ff @(posedge clk) begin
      if (!rst_n) cyc_ctrl <= '0;
      else if (wr_to(RK_CYC_CTRL, dec.kind, wr_hit)) cyc_ctrl <= reg_wdata[REG_W-1:0];
   end

   pmc_counter #(.CW(CYC_W)) u_cyc (
      .clk(clk), .rst_n(rst_n),
      .hit(cyc_hit), .clr(rst_cyc), .wr(cyc_val_we),
      .wd(reg_wdata[CYC_W-1:0]),
      .q(cyc_cnt), .wrap(cyc_wrap)
   );

   // R6
   cyc_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q && cnt_en[CYC_BIT] && !cyc_val_we && !rst_cyc) |=> (cyc_cnt == $past(cyc_cnt) + 1'b1));

   // R2
   cyc_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_q && !cyc_val_we && !rst_cyc) |=> $stable(cyc_cnt));

   // R9
   cyc_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_wrap && int_en[CYC_BIT] && !ie_clr_we) |=> irq);

   // ---------------- read path ----------------
   logic [DATA_W-1:0] rd_val;
   logic [IDX_W-1:0]  ridx;
   assign ridx = dec.ctr[IDX_W-1:0];

   always_comb begin
      rd_val = '0;
      case (dec.kind)
         RK_GCTRL: begin
            rd_val[CNT_LSB +: CNT_W] = CNT_W'(NUM_EVT);
            rd_val[G_EN_BIT]         = en_q;
         end
         RK_EN_CLR, RK_EN_SET: rd_val = DATA_W'(cnt_en);
         RK_IE_CLR, RK_IE_SET: rd_val = DATA_W'(int_en);
         RK_OV_CLR, RK_OV_SET: rd_val = DATA_W'(ovf);
         RK_CYC_CTRL:          rd_val = DATA_W'(cyc_ctrl);
         RK_CYC_VAL:           rd_val = DATA_W'(cyc_cnt);
         RK_EV_CTRL:           rd_val = DATA_W'(ev_ctrl[ridx]);
         RK_EV_VAL:            rd_val = DATA_W'(ev_cnt[ridx]);
         RK_EV_FILT:           rd_val = DATA_W'(ev_filt[ridx]);
         RK_EV_TYPE:           rd_val = DATA_W'(ev_type[ridx]);
         default:              rd_val = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      reg_rdata <= '0;
      else if (rd_hit) reg_rdata <= rd_val;
   end

   // R10
   rd_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_hit && dec.kind == RK_GCTRL) |=> (reg_rdata[CNT_LSB +: CNT_W] == CNT_W'(NUM_EVT)));

   // R10
   rd_unmapped_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_hit && dec.kind == RK_NONE) |=> (reg_rdata == '0));

endmodule

// File: tb/sim_pmc_bank.sv
`timescale 1ns/1ps
module sim_pmc_bank;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] evt_strobe = '0;
   logic        reg_valid = 1'b0;
   logic        reg_write = 1'b0;
   logic [11:0] reg_index = '0;
   logic [63:0] reg_wdata = '0;
   logic [63:0] reg_rdata;
   logic        irq;

   int n_checks = 0;
   int n_fail   = 0;

   always #2.5 clk = ~clk;

   pmc_bank u0 (
      .clk(clk), .rst_n(rst_n), .evt_strobe(evt_strobe),
      .reg_valid(reg_valid), .reg_write(reg_write), .reg_index(reg_index),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [63:0] d);
      @(negedge clk);
      reg_valid = 1'b1; reg_write = 1'b1; reg_index = a; reg_wdata = d;
      @(negedge clk);
      reg_valid = 1'b0; reg_write = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [63:0] d);
      @(negedge clk);
      reg_valid = 1'b1; reg_write = 1'b0; reg_index = a;
      @(negedge clk);
      reg_valid = 1'b0;
      d = reg_rdata;
   endtask

   task automatic pulse(input int idx, input int n);
      @(negedge clk);
      evt_strobe[idx] = 1'b1;
      repeat (n) @(negedge clk);
      evt_strobe[idx] = 1'b0;
   endtask

   task automatic t_reset();
      logic [63:0] v;
      chk("R1 irq", {63'd0, irq}, 64'd0);
      rd(12'h400, v); chk("R2 ctrl count field", v, 64'h4000);
      rd(12'h421, v); chk("R1 ev0 value", v, 64'd0);
      rd(12'h40A, v); chk("R1 cycle value", v, 64'd0);
      rd(12'h404, v); chk("R1 enable mask", v, 64'd0);
      rd(12'h408, v); chk("R1 overflow mask", v, 64'd0);
   endtask

   task automatic t_count();
      logic [63:0] v;
      wr(12'h424, 64'd3);
      wr(12'h404, 64'h1);
      wr(12'h400, 64'h1);
      pulse(3, 5);
      pulse(4, 3);
      wr(12'h400, 64'h0);
      rd(12'h421, v); chk("R4 selected strobe count", v, 64'd5);
      pulse(3, 2);
      rd(12'h421, v); chk("R2 stopped while disabled", v, 64'd5);
   endtask

   task automatic t_badsel();
      logic [63:0] v;
      wr(12'h454, 64'hFF);
      wr(12'h404, 64'h8);
      wr(12'h400, 64'h1);
      pulse(0, 4);
      wr(12'h400, 64'h0);
      rd(12'h451, v); chk("R4 out-of-range type", v, 64'd0);
   endtask

   task automatic t_wrap();
      logic [63:0] v;
      wr(12'h431, 64'hFFFF_FFFE);
      wr(12'h434, 64'd0);
      wr(12'h404, 64'h2);
      wr(12'h406, 64'h2);
      wr(12'h400, 64'h1);
      pulse(0, 2);
      wr(12'h400, 64'h0);
      rd(12'h431, v); chk("R5 wrap to zero", v, 64'd0);
      rd(12'h408, v); chk("R5 overflow bit 1", v, 64'h2);
      chk("R9 irq raised", {63'd0, irq}, 64'd1);
      repeat (3) @(negedge clk);
      chk("R9 irq held", {63'd0, irq}, 64'd1);
      wr(12'h407, 64'h2);
      chk("R9 irq cleared", {63'd0, irq}, 64'd0);
      rd(12'h407, v); chk("R3 overflow cleared", v, 64'd0);
   endtask

   task automatic t_cycle();
      logic [63:0] v;
      wr(12'h40A, 64'hFFFF_FFFF_FFFF_FFFD);
      wr(12'h404, 64'h8000_0000);
      wr(12'h400, 64'h1);
      repeat (10) @(negedge clk);
      wr(12'h400, 64'h0);
      rd(12'h408, v); chk("R6 cycle overflow bit 31", v, 64'h8000_0000);
      rd(12'h40A, v); chk("R6 cycle wrapped small", {63'd0, (v > 0 && v < 32)}, 64'd1);
      chk("R9 no irq without enable", {63'd0, irq}, 64'd0);
   endtask

   task automatic t_write_wins();
      logic [63:0] v;
      wr(12'h444, 64'd5);
      wr(12'h404, 64'h4);
      wr(12'h400, 64'h1);
      @(negedge clk);
      evt_strobe[5] = 1'b1;
      repeat (3) @(negedge clk);
      reg_valid = 1'b1; reg_write = 1'b1; reg_index = 12'h441; reg_wdata = 64'd100;
      @(negedge clk);
      reg_valid = 1'b0; reg_write = 1'b0; evt_strobe[5] = 1'b0;
      wr(12'h400, 64'h0);
      rd(12'h441, v); chk("R8 write beats increment", v, 64'd100);
   endtask

   task automatic t_masks();
      logic [63:0] v;
      rd(12'h403, v); chk("R3 enable via clear addr", v, 64'h8000_000F);
      wr(12'h404, 64'h0010_0000);
      rd(12'h404, v); chk("R3 unimplemented bit", v, 64'h8000_000F);
      wr(12'h403, 64'h8);
      rd(12'h404, v); chk("R3 enable clear", v, 64'h8000_0007);
      rd(12'h405, v); chk("R3 interrupt mask", v, 64'h2);
   endtask

   task automatic t_regs();
      logic [63:0] v;
      wr(12'h420, 64'hFFFF_FFFF_0000_1234);
      wr(12'h473, 64'h000E_0007);
      wr(12'h409, 64'h55);
      rd(12'h420, v); chk("R11 ev0 control", v, 64'h1234);
      rd(12'h473, v); chk("R11 ev5 filter", v, 64'h000E_0007);
      rd(12'h409, v); chk("R11 cycle control", v, 64'h55);
   endtask

   task automatic t_unmapped();
      logic [63:0] v;
      wr(12'h4A1, 64'h77);
      rd(12'h4A1, v); chk("R10 counter beyond count", v, 64'd0);
      wr(12'h422, 64'h99);
      rd(12'h422, v); chk("R10 unmapped slot", v, 64'd0);
      rd(12'h401, v); chk("R10 unmapped index", v, 64'd0);
      rd(12'h421, v); chk("R10 neighbour untouched", v, 64'd5);
   endtask

   task automatic t_reset_all();
      logic [63:0] v;
      wr(12'h400, 64'h6);
      rd(12'h421, v); chk("R7 ev0 zeroed", v, 64'd0);
      rd(12'h441, v); chk("R7 ev2 zeroed", v, 64'd0);
      rd(12'h40A, v); chk("R7 cycle zeroed", v, 64'd0);
      rd(12'h404, v); chk("R7 enables kept", v, 64'h8000_0007);
      rd(12'h400, v); chk("R2 enable readback", v, 64'h4000);
   endtask

   initial begin
      fork
         begin
            repeat (4) @(negedge clk);
            rst_n = 1'b1;
            t_reset();
            t_count();
            t_badsel();
            t_wrap();
            t_cycle();
            t_write_wins();
            t_masks();
            t_regs();
            t_unmapped();
            t_reset_all();
         end
         begin
            repeat (100000) @(posedge clk);
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=done");
         end
      join_any
      disable fork;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule